// File: doc/BRIEF.md
# DMA Channel Register Block

This block holds the programming state of a single DMA channel. Software reaches it over a 32-bit register bus and programs five address registers: the current pointer, its limit, a reload start, a reload stop, and an initial-buffer pointer. It can also program a size word. Each of these is a plain store that reads back what was written.

The command/status register works differently. A write to it is a set of one-shot commands. Individual bits set the enable, single-update and direction flags, clear the complete flag, or reset all four flags at once. A status flag changes only through these commands or through the channel's own progress.

A small advance engine is built in. While the channel is enabled, every transfer strobe from the device moves the current pointer forward by one word. When the moved pointer lands on the limit, the channel marks itself complete and raises its interrupt. It then does one of two things. In single-update mode it stops. Otherwise it reloads the pointer and limit from the start and stop registers and keeps running.

Top module: `dma_chan_regs`

## Requirements
- R1: After the synchronous active-low reset, every register reads zero and `irq` is low.
- R2: Full-word writes to offsets 0x4000 (next), 0x4004 (limit), 0x4008 (start), 0x400C (stop), 0x4200 (initial buffer) and 0x4204 (size) are stored, and reads of these offsets return the stored value combinationally in the same cycle.
- R3: A read of any other offset (except 0x0000) returns zero. A write to such an offset changes no register.
- R4: An access whose byte enables are not all ones is not a valid access. If it is a write, it is ignored; if it is a read, it returns zero.
- R5: A write to offset 0x0000 is a command word. Bit 0 sets direction, bit 2 sets enable, bit 3 sets single-update, and bit 4 clears complete. Command bits written as zero leave the flags unchanged. Reading 0x0000 returns enable in bit 0, single-update in bit 1, complete in bit 2 and direction in bit 3, with zeros above.
- R6: Command bit 1 (reset) clears enable, single-update, complete and direction together. It overrides any set bit in the same write and any completion in the same cycle.
- R7: While enabled, each cycle with `xfer_strobe` high adds 4 to next, visible the following cycle. While not enabled, the strobe has no effect.
- R8: When a strobe makes next plus 4 equal limit, complete is set. `irq` follows complete and stays high until a clear-complete or reset command.
- R9: At completion with single-update clear, next is loaded from start, limit is loaded from stop, and enable stays set.
- R10: At completion with single-update set, enable is cleared and next holds the limit value.
- R11: A bus write to next or limit in the same cycle as an engine update wins. A completion in the same cycle as a clear-complete command leaves complete set. A set-enable command in the same cycle as a single-update completion leaves enable set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_be | input | DATA_W/8 | Byte enables; only all ones is valid |
| bus_wdata | input | DATA_W | Write data or command word |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle |
| xfer_strobe | input | 1 | One word moved by the device |
| irq | output | 1 | Channel complete interrupt (level) |

## Verification
Read data is combinational. The bench therefore compares it 1 ns after driving the request, before the edge that closes the cycle. Writes, commands and strobes take effect at that edge. Their results, including `irq`, are due one cycle later, and the bench samples them 1 ns after the edge, once every register on the path has updated. A cycle-level model in the bench applies the same one-edge latency and the priority rules of R6 and R11, so random mixes of commands, pointer writes and strobes are checked against it at those instants.

// File: rtl/dma_chan_pkg.sv
// Shared offsets, command bit positions and types for the DMA channel block.
package dma_chan_pkg;

    localparam logic [15:0] OFS_CSR   = 16'h0000;
    localparam logic [15:0] OFS_NEXT  = 16'h4000;
    localparam logic [15:0] OFS_LIMIT = 16'h4004;
    localparam logic [15:0] OFS_START = 16'h4008;
    localparam logic [15:0] OFS_STOP  = 16'h400C;
    localparam logic [15:0] OFS_INIT  = 16'h4200;
    localparam logic [15:0] OFS_SIZE  = 16'h4204;

    localparam int CMD_DIR        = 0;
    localparam int CMD_RESET      = 1;
    localparam int CMD_SET_EN     = 2;
    localparam int CMD_SET_SINGLE = 3;
    localparam int CMD_CLR_DONE   = 4;

    typedef enum logic [2:0] {
        RS_NONE, RS_CSR, RS_NEXT, RS_LIMIT, RS_START, RS_STOP, RS_INIT, RS_SIZE
    } reg_sel_e;

    // Packed so that enable lands in bit 0 and direction in bit 3.
    typedef struct packed {
        logic dir;
        logic complete;
        logic single;
        logic enable;
    } chan_stat_t;

endpackage

// File: rtl/dma_reg_decode.sv
// Address decoder: maps a bus offset to a register select.
// Assumes ADDR_W >= 16. A partial byte enable yields RS_NONE.
module dma_reg_decode
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BE_W   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    output reg_sel_e          sel
);

    // Pick the register for a full-word access, otherwise nothing.
    always_comb begin
        sel = RS_NONE;
        if (&be) begin
            unique case (addr)
                ADDR_W'(OFS_CSR):   sel = RS_CSR;
                ADDR_W'(OFS_NEXT):  sel = RS_NEXT;
                ADDR_W'(OFS_LIMIT): sel = RS_LIMIT;
                ADDR_W'(OFS_START): sel = RS_START;
                ADDR_W'(OFS_STOP):  sel = RS_STOP;
                ADDR_W'(OFS_INIT):  sel = RS_INIT;
                ADDR_W'(OFS_SIZE):  sel = RS_SIZE;
                default:            sel = RS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dma_plain_regs.sv
// Bank of N plain storage registers with individual write enables.
// No side effects; used for start, stop, initial buffer and size.
module dma_plain_regs #(
    parameter int DATA_W = 32,
    parameter int N      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q [N]
);

    for (genvar i = 0; i < N; i++) begin : g_reg
        // Store the bus word when this register is written.
        always_ff @(posedge clk) begin
            if (!rst_n)        q[i] <= '0;
            else if (wr_en[i]) q[i] <= wdata;
        end
    end

endmodule

// File: rtl/dma_ptr_engine.sv
// Pointer advance engine: holds next and limit, and steps next by STEP on
// each enabled strobe. It flags a hit when the stepped value equals limit,
// and on a hit reloads from start/stop unless single-update is set.
// Bus writes to next/limit take priority over engine updates.
module dma_ptr_engine #(
    parameter int DATA_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              single,
    input  logic              strobe,
    input  logic              wr_next,
    input  logic              wr_limit,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] start_val,
    input  logic [DATA_W-1:0] stop_val,
    output logic [DATA_W-1:0] next_q,
    output logic [DATA_W-1:0] limit_q,
    output logic              hit
);

    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    logic              adv;
    logic [DATA_W-1:0] next_inc;
    logic              reload;

    // Step condition and terminal-count compare on the stepped value.
    always_comb begin
        adv      = enable && strobe;
        next_inc = next_q + STEP_V;
        hit      = adv && (next_inc == limit_q);
        reload   = hit && !single;
    end

    // Current pointer: bus write, then reload, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)       next_q <= '0;
        else if (wr_next) next_q <= wdata;
        else if (reload)  next_q <= start_val;
        else if (adv)     next_q <= next_inc;
    end

    // Limit: bus write, then reload.
    always_ff @(posedge clk) begin
        if (!rst_n)        limit_q <= '0;
        else if (wr_limit) limit_q <= wdata;
        else if (reload)   limit_q <= stop_val;
    end

endmodule

// File: rtl/dma_csr_ctrl.sv
// Command/status flags. A command write sets or clears flags one-shot;
// the reset command overrides all. A hit sets complete and, in
// single-update mode, drops enable unless set-enable arrives together.
module dma_csr_ctrl
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd,
    input  logic              hit,
    output chan_stat_t        stat_q
);

    logic c_rst, c_dir, c_en, c_sgl, c_clr;

    // Qualify the command bits with the write strobe.
    always_comb begin
        c_rst = cmd_wr && cmd[CMD_RESET];
        c_dir = cmd_wr && cmd[CMD_DIR];
        c_en  = cmd_wr && cmd[CMD_SET_EN];
        c_sgl = cmd_wr && cmd[CMD_SET_SINGLE];
        c_clr = cmd_wr && cmd[CMD_CLR_DONE];
    end

    // Enable flag: reset, set, then single-update completion.
    always_ff @(posedge clk) begin
        if (!rst_n || c_rst)           stat_q.enable <= 1'b0;
        else if (c_en)                 stat_q.enable <= 1'b1;
        else if (hit && stat_q.single) stat_q.enable <= 1'b0;
    end

    // Single-update flag: set by command, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n || c_rst) stat_q.single <= 1'b0;
        else if (c_sgl)      stat_q.single <= 1'b1;
    end

    // Complete flag: a completion beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || c_rst) stat_q.complete <= 1'b0;
        else if (hit)        stat_q.complete <= 1'b1;
        else if (c_clr)      stat_q.complete <= 1'b0;
    end

    // Direction flag: set by command, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n || c_rst) stat_q.dir <= 1'b0;
        else if (c_dir)      stat_q.dir <= 1'b1;
    end

endmodule

// File: rtl/dma_chan_regs.sv
// One DMA channel's register block: decode, command/status flags, pointer
// engine and plain address registers, with a combinational read mux.
// Assumes one access per cycle when bus_sel is high; full words only.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int ADDR_W = 16,
    parameter  int STEP   = 4,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              xfer_strobe,
    output logic              irq
);

    localparam int N_PLAIN = 4;
    localparam int P_START = 0;
    localparam int P_STOP  = 1;
    localparam int P_INIT  = 2;
    localparam int P_SIZE  = 3;

    reg_sel_e          sel;
    logic              wr_go;
    logic [N_PLAIN-1:0] plain_we;
    logic [DATA_W-1:0] plain_q [N_PLAIN];
    chan_stat_t        stat_q;
    logic [DATA_W-1:0] next_q;
    logic [DATA_W-1:0] limit_q;
    logic              hit;

    dma_reg_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
        .addr (bus_addr),
        .be   (bus_be),
        .sel  (sel)
    );

    // Per-register write strobes for the plain bank.
    always_comb begin
        wr_go                 = bus_sel && bus_wr;
        plain_we              = '0;
        plain_we[P_START]     = wr_go && (sel == RS_START);
        plain_we[P_STOP]      = wr_go && (sel == RS_STOP);
        plain_we[P_INIT]      = wr_go && (sel == RS_INIT);
        plain_we[P_SIZE]      = wr_go && (sel == RS_SIZE);
    end

    dma_plain_regs #(.DATA_W(DATA_W), .N(N_PLAIN)) u_plain (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (plain_we),
        .wdata (bus_wdata),
        .q     (plain_q)
    );

    dma_ptr_engine #(.DATA_W(DATA_W), .STEP(STEP)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (stat_q.enable),
        .single    (stat_q.single),
        .strobe    (xfer_strobe),
        .wr_next   (wr_go && (sel == RS_NEXT)),
        .wr_limit  (wr_go && (sel == RS_LIMIT)),
        .wdata     (bus_wdata),
        .start_val (plain_q[P_START]),
        .stop_val  (plain_q[P_STOP]),
        .next_q    (next_q),
        .limit_q   (limit_q),
        .hit       (hit)
    );

    dma_csr_ctrl #(.DATA_W(DATA_W)) u_csr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_wr (wr_go && (sel == RS_CSR)),
        .cmd    (bus_wdata),
        .hit    (hit),
        .stat_q (stat_q)
    );

    // Read mux; unmapped or partial accesses return zero.
    always_comb begin
        unique case (sel)
            RS_CSR:   bus_rdata = DATA_W'(stat_q);
            RS_NEXT:  bus_rdata = next_q;
            RS_LIMIT: bus_rdata = limit_q;
            RS_START: bus_rdata = plain_q[P_START];
            RS_STOP:  bus_rdata = plain_q[P_STOP];
            RS_INIT:  bus_rdata = plain_q[P_INIT];
            RS_SIZE:  bus_rdata = plain_q[P_SIZE];
            default:  bus_rdata = '0;
        endcase
    end

    // Interrupt is the complete flag as a level.
    assign irq = stat_q.complete;

endmodule

// File: rtl/dma_chan_regs_chk.sv
// Property checker for dma_chan_regs, attached by bind below.
module dma_chan_regs_chk
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [BE_W-1:0]   bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input reg_sel_e          sel,
    input chan_stat_t        stat_q,
    input logic [DATA_W-1:0] next_q,
    input logic [DATA_W-1:0] start_q,
    input logic [DATA_W-1:0] stop_q,
    input logic              hit,
    input logic              irq
);

    logic rst_cmd;
    assign rst_cmd = bus_sel && bus_wr && (sel == RS_CSR) && bus_wdata[CMD_RESET];

    // R6: a reset command leaves all flags clear next cycle.
    a_r6_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (stat_q == '0));

    // R7: without enable, next moves only by a bus write.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_q.enable && !(bus_sel && bus_wr && sel == RS_NEXT)) |=> $stable(next_q));

    // R4: a partial-enable write does not disturb start or stop.
    a_r4_partial_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !(&bus_be)) |=> ($stable(start_q) && $stable(stop_q)));

    // R3: unmapped reads return zero.
    a_r3_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && sel == RS_NONE) |-> (bus_rdata == '0));

    // R8: the interrupt rises only after a completing strobe.
    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit));

    // R10: enable drops only on a reset command or single-update completion.
    a_r10_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q.enable) |-> ($past(rst_cmd) || $past(hit && stat_q.single)));

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sel       (sel),
    .stat_q    (stat_q),
    .next_q    (next_q),
    .start_q   (plain_q[0]),
    .stop_q    (plain_q[1]),
    .hit       (hit),
    .irq       (irq)
);

// File: tb/tb_dma_chan_regs.sv
// Bench: directed corner cases, then seeded random traffic against a model.
module tb_dma_chan_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        xfer_strobe = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dma_chan_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .xfer_strobe(xfer_strobe), .irq(irq)
    );

    // Model state, written from the requirements.
    logic [31:0] m_next, m_limit, m_start, m_stop, m_init, m_size;
    logic        m_en, m_sgl, m_cmp, m_dir;

    function automatic logic [31:0] model_read(input logic [15:0] a, input logic [3:0] be);
        if (be != 4'hF) return 32'h0;                                  // R4
        case (a)
            16'h0000: return {28'h0, m_dir, m_cmp, m_sgl, m_en};       // R5
            16'h4000: return m_next;
            16'h4004: return m_limit;
            16'h4008: return m_start;
            16'h400C: return m_stop;
            16'h4200: return m_init;
            16'h4204: return m_size;
            default:  return 32'h0;                                    // R3
        endcase
    endfunction

    task automatic model_reset();
        {m_next, m_limit, m_start, m_stop, m_init, m_size} = '0;
        {m_en, m_sgl, m_cmp, m_dir} = '0;
    endtask

    task automatic model_step(input logic s, w, input logic [15:0] a,
                              input logic [3:0] be, input logic [31:0] d, input logic stb);
        logic wv, adv, hitm, c_rst;
        logic [31:0] inc, nn, nl;
        wv   = s && w && (be == 4'hF);
        adv  = m_en && stb;
        inc  = m_next + 32'd4;
        hitm = adv && (inc == m_limit);
        nn = m_next; nl = m_limit;
        if (hitm && !m_sgl) begin nn = m_start; nl = m_stop; end       // R9
        else if (adv) nn = inc;                                        // R7
        if (wv && a == 16'h4000) nn = d;                               // R11
        if (wv && a == 16'h4004) nl = d;
        c_rst = wv && a == 16'h0000 && d[1];
        if (c_rst) {m_en, m_sgl, m_cmp, m_dir} = '0;                   // R6
        else begin
            if (wv && a == 16'h0000 && d[2]) m_en = 1'b1;
            else if (hitm && m_sgl) m_en = 1'b0;                       // R10
            if (wv && a == 16'h0000 && d[3]) m_sgl = 1'b1;
            if (hitm) m_cmp = 1'b1;                                    // R8
            else if (wv && a == 16'h0000 && d[4]) m_cmp = 1'b0;
            if (wv && a == 16'h0000 && d[0]) m_dir = 1'b1;
        end
        m_next = nn; m_limit = nl;
        if (wv && a == 16'h4008) m_start = d;
        if (wv && a == 16'h400C) m_stop = d;
        if (wv && a == 16'h4200) m_init = d;
        if (wv && a == 16'h4204) m_size = d;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle; a read is compared before the edge, irq after it.
    task automatic cyc(input logic s, w, input logic [15:0] a, input logic [3:0] be,
                       input logic [31:0] d, input logic stb, input string tag,
                       input bit use_exp, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_be = be; bus_wdata = d; xfer_strobe = stb;
        #1;
        if (s && !w) chk(tag, bus_rdata, use_exp ? exp : model_read(a, be));
        @(posedge clk);
        model_step(s, w, a, be, d, stb);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; xfer_strobe = 1'b0;
        chk({tag, " irq"}, {31'h0, irq}, {31'h0, m_cmp});
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, 4'hF, d, 1'b0, "write", 1'b0, 32'h0);
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b1, 1'b0, a, 4'hF, 32'h0, 1'b0, tag, 1'b1, exp);
    endtask

    task automatic strobe(input string tag);
        cyc(1'b0, 1'b0, 16'h0, 4'h0, 32'h0, 1'b1, tag, 1'b0, 32'h0);
    endtask

    function automatic logic [15:0] pick_addr(input int k);
        case (k % 9)
            0: return 16'h0000; 1: return 16'h4000; 2: return 16'h4004;
            3: return 16'h4008; 4: return 16'h400C; 5: return 16'h4200;
            6: return 16'h4204; 7: return 16'h4010; default: return 16'h0004;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(16'h0000, 32'h0, "R1 csr");
        rd(16'h4000, 32'h0, "R1 next");
        rd(16'h4204, 32'h0, "R1 size");

        // R2: store and read back
        wr(16'h4000, 32'h0000_0100); wr(16'h4004, 32'h0000_010C);
        wr(16'h4008, 32'h0000_0200); wr(16'h400C, 32'h0000_0208);
        wr(16'h4200, 32'hCAFE_0000); wr(16'h4204, 32'h0000_1234);
        rd(16'h4000, 32'h0000_0100, "R2 next");
        rd(16'h400C, 32'h0000_0208, "R2 stop");
        rd(16'h4200, 32'hCAFE_0000, "R2 init");
        rd(16'h4204, 32'h0000_1234, "R2 size");

        // R3: unmapped write and read
        wr(16'h4010, 32'hFFFF_FFFF);
        rd(16'h4010, 32'h0, "R3 unmapped read");
        rd(16'h4008, 32'h0000_0200, "R3 start untouched");

        // R4: partial byte enables
        cyc(1'b1, 1'b1, 16'h4008, 4'h3, 32'hDEAD_BEEF, 1'b0, "R4 partial write", 1'b0, 32'h0);
        rd(16'h4008, 32'h0000_0200, "R4 start kept");
        cyc(1'b1, 1'b0, 16'h4008, 4'h1, 32'h0, 1'b0, "R4 partial read", 1'b1, 32'h0);

        // R7: strobe while disabled
        strobe("R7 idle strobe");
        rd(16'h4000, 32'h0000_0100, "R7 next held");

        // R5: set direction, enable, single-update
        wr(16'h0000, 32'h0000_000D);
        rd(16'h0000, 32'h0000_000B, "R5 status");

        // R7/R8/R10: step to limit in single-update mode
        strobe("R7 step1");
        rd(16'h4000, 32'h0000_0104, "R7 next+4");
        strobe("R7 step2");
        strobe("R8 complete");
        chk("R8 irq high", {31'h0, irq}, 32'h1);
        rd(16'h0000, 32'h0000_000E, "R10 enable cleared");
        rd(16'h4000, 32'h0000_010C, "R10 next at limit");

        // R8: clear-complete drops irq
        wr(16'h0000, 32'h0000_0010);
        chk("R8 irq cleared", {31'h0, irq}, 32'h0);

        // R6: reset command overrides set bits
        wr(16'h0000, 32'h0000_000E);
        rd(16'h0000, 32'h0, "R6 reset wins");

        // R9: reload mode
        wr(16'h4000, 32'h0000_0100); wr(16'h4004, 32'h0000_0104);
        wr(16'h400C, 32'h0000_020C);
        wr(16'h0000, 32'h0000_0004);
        strobe("R9 complete");
        rd(16'h4000, 32'h0000_0200, "R9 next reload");
        rd(16'h4004, 32'h0000_020C, "R9 limit reload");
        rd(16'h0000, 32'h0000_0005, "R9 enable kept");

        // R11: bus write beats step; completion beats clear
        cyc(1'b1, 1'b1, 16'h4000, 4'hF, 32'h0000_0300, 1'b1, "R11 write vs step", 1'b0, 32'h0);
        rd(16'h4000, 32'h0000_0300, "R11 write wins");
        wr(16'h0000, 32'h0000_0010);
        wr(16'h4000, 32'h0000_0208);
        cyc(1'b1, 1'b1, 16'h0000, 4'hF, 32'h0000_0010, 1'b1, "R11 done vs clear", 1'b0, 32'h0);
        rd(16'h0000, 32'h0000_0005, "R11 complete kept");

        // Random traffic against the model (R2 R5 R7 R8 R9 R10 R11)
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 8);
            d  = 32'h1000 + 32'(($urandom % 16) * 4);
            case (op)
                0: wr(16'h4000, d);
                1: wr(16'h4004, d);
                2: wr(16'h4008, d);
                3: wr(16'h400C, d);
                4: wr(16'h0000, {27'h0, 5'($urandom) & (($urandom % 6 == 0) ? 5'h1F : 5'h1D)});
                5: cyc(1'b1, 1'b0, pick_addr(int'($urandom % 9)),
                       ($urandom % 8 == 0) ? 4'h7 : 4'hF, 32'h0, 1'b0, "R2 random read", 1'b0, 32'h0);
                default: cyc(1'b1, 1'b0, pick_addr(int'($urandom % 9)), 4'hF, 32'h0, 1'b1,
                             "R7 random strobe", 1'b0, 32'h0);
            endcase
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule